// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block gathers 32 interrupt request lines into one controller. Each line passes through a two-stage synchroniser. A per-source trigger bit selects level or edge sensitivity, and a per-source polarity bit selects the active level or the active edge. Each detected request is latched into a pending-status register. Software clears a pending bit by writing a one to it. A bit whose level-sensitive input is still active cannot be cleared.

Pending bits are gated by an enable mask. Each surviving bit is steered to one of two registered outputs by a per-source urgency-select bit: a normal-priority output and an urgent output. All registers sit on a small word-addressed register bus with separate read and write strobes. Read data is returned one cycle after the read strobe.

Source n always occupies bit 31-n of every per-source register, so source 0 is the most significant bit.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, pending, enable, urgency-select and trigger registers read 0, polarity reads 0xFFFFFFFF, and both outputs are low.
- R2: Source n (input bit n of `irq_req`) is reported at bit 31-n of every per-source register.
- R3: With trigger bit 0 (level), the pending bit is set every cycle the synchronised input equals the polarity bit (1 = active high, 0 = active low).
- R4: With trigger bit 1 (edge), the pending bit is set only on a transition into the polarity level (1 = rising, 0 = falling). It stays set after the input returns.
- R5: Writing 1 to a pending bit at offset 0x0 clears it. Writing 0 leaves it unchanged.
- R6: A level-sensitive pending bit whose input is still active stays set after a clear write, even when the source is disabled.
- R7: Pending bits latch whether or not the source is enabled, and clearing an enable bit does not clear its pending bit.
- R8: Offset 0x6 reads the bitwise AND of pending (0x0) and enable (0x2).
- R9: The normal output is the OR of enabled pending bits whose urgency-select bit (offset 0x3) is 0. The urgent output is the OR of those whose bit is 1. Both are registered.
- R10: When a detected request and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R11: The offsets are: pending 0x0, enable 0x2, urgency-select 0x3, polarity 0x4, trigger 0x5, masked 0x6. Any other offset, including 0x7 and 0x8, reads zero. Read data is valid on the clock edge after the cycle the read strobe is sampled.
- R12: An input change sampled at clock edge k appears in the pending register at edge k+2 and on an output at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 32 | Asynchronous request lines, bit n = source n |
| reg_addr | input | 4 | Word offset of the accessed register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| irq_normal | output | 1 | Normal-priority interrupt output |
| irq_urgent | output | 1 | Urgent interrupt output |

## Verification
A request changed between edges is seen by the first synchroniser flop at the next edge and reaches the pending register two edges later. The output flop adds one more edge, and a read adds one edge after the strobe. The bench drives every input at the falling edge and samples at the next falling edge. Table vectors wait six cycles after each stimulus, which is beyond every latency. The directed latency test counts edges one by one: it checks that the output is still low after the third edge and high after the fourth. It also places a clear write on exactly the edge at which the pending bit is set.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt aggregator: sizes and register offsets.
package irqc_pkg;
    localparam int NSRC   = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_PEND   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_URGENT = 4'h3;
    localparam logic [ADDR_W-1:0] OFS_POL    = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_TRIG   = 4'h5;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 4'h6;
endpackage

// File: rtl/irqc_sync.sv
// Two-flop synchroniser for a vector of asynchronous request lines.
// Assumes each bit is independent; no multi-bit coherency is provided.
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two register stages per line to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/irqc_detect.sv
// Per-source request detector. Produces a one-cycle set strobe per bit:
// continuous while a level source is active, single on a qualifying edge.
// Assumes inputs are already synchronous.
module irqc_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_in,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] trig,
    output logic [W-1:0] set_vec
);
    logic [W-1:0] prev_q;

    // Remember the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= line_in;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic at_level;
        logic was_level;
        // Matching level now and one sample earlier decide the strobe.
        always_comb begin
            at_level   = (line_in[b] == pol[b]);
            was_level  = (prev_q[b] == pol[b]);
            set_vec[b] = trig[b] ? (at_level && !was_level) : at_level;
        end
    end

    // R4
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & trig) != '0) |=> (((set_vec & trig) & $past(set_vec & trig)) == '0)
            || ($past(trig) != trig) || ($past(pol) != pol));
endmodule

// File: rtl/irqc_regs.sv
// Register file for the aggregator: pending (write-one-to-clear),
// enable, urgency-select, polarity and trigger, plus the registered read path.
// Assumes single-cycle write strobe and word addressing.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int W = NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [W-1:0]      reg_wdata,
    input  logic              reg_rd,
    output logic [W-1:0]      reg_rdata,
    input  logic [W-1:0]      set_vec,
    output logic [W-1:0]      pend_q,
    output logic [W-1:0]      enable_q,
    output logic [W-1:0]      urgent_q,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      trig_q
);
    logic [W-1:0] clr_vec;
    logic [W-1:0] masked;
    logic [W-1:0] rd_mux;

    // Clear mask comes only from a write to the pending offset.
    always_comb begin
        clr_vec = (reg_wr && reg_addr == OFS_PEND) ? reg_wdata : '0;
        masked  = pend_q & enable_q;
    end

    // Pending bits: detected requests take precedence over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    // Configuration registers with plain write semantics.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            urgent_q <= '0;
            pol_q    <= '1;
            trig_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_ENABLE) enable_q <= reg_wdata;
            if (reg_addr == OFS_URGENT) urgent_q <= reg_wdata;
            if (reg_addr == OFS_POL)    pol_q    <= reg_wdata;
            if (reg_addr == OFS_TRIG)   trig_q   <= reg_wdata;
        end
    end

    // Read selector; unused offsets return zero.
    always_comb begin
        unique case (reg_addr)
            OFS_PEND:   rd_mux = pend_q;
            OFS_ENABLE: rd_mux = enable_q;
            OFS_URGENT: rd_mux = urgent_q;
            OFS_POL:    rd_mux = pol_q;
            OFS_TRIG:   rd_mux = trig_q;
            OFS_MASKED: rd_mux = masked;
            default:    rd_mux = '0;
        endcase
    end

    // Capture read data on the strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    // R7
    rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));

    // R6
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & ~trig_q) != '0) |=>
            ((pend_q & $past(set_vec & ~trig_q)) == $past(set_vec & ~trig_q)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && enable_q == '0 && pol_q == '1));
endmodule

// File: rtl/irq_aggregator.sv
// Top of the interrupt aggregator. Maps source n to bit 31-n, synchronises
// and detects requests, holds the registers and drives two registered outputs.
// Assumes irq_req is asynchronous and the register bus is synchronous to clk.
module irq_aggregator
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NSRC-1:0]   reg_wdata,
    input  logic              reg_rd,
    output logic [NSRC-1:0]   reg_rdata,
    output logic              irq_normal,
    output logic              irq_urgent
);
    logic [NSRC-1:0] req_bits;
    logic [NSRC-1:0] sync_bits;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] pend_q, enable_q, urgent_q, pol_q, trig_q;
    logic [NSRC-1:0] active;

    // Reverse order: source n lands on bit NSRC-1-n.
    for (genvar n = 0; n < NSRC; n++) begin : g_map
        assign req_bits[NSRC-1-n] = irq_req[n];
    end

    irqc_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(req_bits), .sync_out(sync_bits)
    );

    irqc_detect #(.W(NSRC)) u_detect (
        .clk(clk), .rst_n(rst_n), .line_in(sync_bits),
        .pol(pol_q), .trig(trig_q), .set_vec(set_vec)
    );

    irqc_regs #(.W(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .set_vec(set_vec), .pend_q(pend_q), .enable_q(enable_q),
        .urgent_q(urgent_q), .pol_q(pol_q), .trig_q(trig_q)
    );

    // Enabled pending bits feed the output OR trees.
    always_comb active = pend_q & enable_q;

    // Register both outputs, split by urgency select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_normal <= 1'b0;
            irq_urgent <= 1'b0;
        end else begin
            irq_normal <= |(active & ~urgent_q);
            irq_urgent <= |(active & urgent_q);
        end
    end

    // R9
    urgent_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_urgent) |-> ($past(pend_q & enable_q & urgent_q) != '0));

    // R9
    normal_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_normal) |-> ($past(pend_q & enable_q & ~urgent_q) != '0));

    // R1
    out_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_normal && !irq_urgent));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq_normal, irq_urgent;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq_normal(irq_normal), .irq_urgent(irq_urgent)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [4:0] src;
        logic trig, pol, urg, en, l0, l1, st, nrm, ugt;
    } vec_t;

    localparam vec_t TBL [0:7] = '{
        '{5'd0,  1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1, 1'b1,1'b1,1'b0},
        '{5'd31, 1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0, 1'b1,1'b0,1'b1},
        '{5'd5,  1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1, 1'b1,1'b1,1'b0},
        '{5'd7,  1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0, 1'b0,1'b0,1'b0},
        '{5'd12, 1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0, 1'b1,1'b0,1'b1},
        '{5'd20, 1'b1,1'b0,1'b0,1'b1, 1'b0,1'b1, 1'b0,1'b0,1'b0},
        '{5'd3,  1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b1,1'b0,1'b0},
        '{5'd16, 1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0, 1'b1,1'b0,1'b1}
    };

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] bitm;

        // R1 / R11: reset values and unused offsets
        do_reset();
        rd(4'h0, v); check("R1 pending", v, 32'h0);
        rd(4'h2, v); check("R1 enable", v, 32'h0);
        rd(4'h3, v); check("R1 urgent", v, 32'h0);
        rd(4'h4, v); check("R1 polarity", v, 32'hFFFFFFFF);
        rd(4'h5, v); check("R1 trigger", v, 32'h0);
        rd(4'h6, v); check("R11 masked", v, 32'h0);
        wr(4'h7, 32'h12345678);
        rd(4'h7, v); check("R11 offset7", v, 32'h0);
        rd(4'h8, v); check("R11 offset8", v, 32'h0);
        check("R1 outputs", {30'h0, irq_normal, irq_urgent}, 32'h0);

        // R2 R3 R4 R8 R9: table walk
        foreach (TBL[i]) begin
            vec_t t = TBL[i];
            bitm = 32'h1 << (31 - t.src);
            do_reset();
            irq_req = '0;
            wr(4'h4, t.pol ? 32'hFFFFFFFF : ~bitm);
            wr(4'h5, t.trig ? bitm : 32'h0);
            wr(4'h3, t.urg ? bitm : 32'h0);
            wr(4'h2, t.en ? bitm : 32'h0);
            irq_req[t.src] = t.l0;
            wait_cyc(6);
            wr(4'h0, 32'hFFFFFFFF);
            wait_cyc(6);
            irq_req[t.src] = t.l1;
            wait_cyc(6);
            rd(4'h0, v);
            check($sformatf("R2/R3/R4 vec%0d pending", i), v, t.st ? bitm : 32'h0);
            rd(4'h6, v);
            check($sformatf("R8 vec%0d masked", i), v, (t.st && t.en) ? bitm : 32'h0);
            check($sformatf("R9 vec%0d normal", i), {31'h0, irq_normal}, {31'h0, t.nrm});
            check($sformatf("R9 vec%0d urgent", i), {31'h0, irq_urgent}, {31'h0, t.ugt});
        end

        // R6: level bit held while input active, even disabled
        do_reset();
        irq_req = '0;
        irq_req[2] = 1'b1;
        wait_cyc(6);
        wr(4'h0, 32'h2000_0000);
        wait_cyc(2);
        rd(4'h0, v); check("R6 held while active", v, 32'h2000_0000);
        irq_req[2] = 1'b0;
        wait_cyc(6);
        wr(4'h0, 32'h2000_0000);
        rd(4'h0, v); check("R6 clears once inactive", v, 32'h0);

        // R5 / R7: edge bit, write-zero, disable keeps pending
        do_reset();
        irq_req = '0;
        wr(4'h5, 32'h0040_0000);
        wr(4'h2, 32'h0040_0000);
        irq_req[9] = 1'b1;
        wait_cyc(6);
        irq_req[9] = 1'b0;
        wait_cyc(6);
        wr(4'h0, 32'h0);
        rd(4'h0, v); check("R5 write zero keeps", v, 32'h0040_0000);
        wr(4'h0, 32'hFFBF_FFFF);
        rd(4'h0, v); check("R5 other ones keep", v, 32'h0040_0000);
        wr(4'h2, 32'h0);
        wait_cyc(2);
        rd(4'h0, v); check("R7 disable keeps pending", v, 32'h0040_0000);
        rd(4'h6, v); check("R7 masked after disable", v, 32'h0);
        check("R7 outputs low after disable", {30'h0, irq_normal, irq_urgent}, 32'h0);
        wr(4'h0, 32'h0040_0000);
        rd(4'h0, v); check("R5 write one clears", v, 32'h0);

        // R12 / R10: exact latency and same-edge set against clear
        do_reset();
        irq_req = '0;
        wr(4'h5, 32'h0800_0000);
        wr(4'h2, 32'h0800_0000);
        @(negedge clk);
        irq_req[4] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R12 output low after two edges", {31'h0, irq_normal}, 32'h0);
        reg_addr = 4'h0; reg_wdata = 32'h0800_0000; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R12 output low after third edge", {31'h0, irq_normal}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R12 output high after fourth edge", {31'h0, irq_normal}, 32'h1);
        rd(4'h0, v); check("R10 set wins over clear", v, 32'h0800_0000);

        summary();
        $finish;
    end
endmodule